// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block recovers bytes from a single asynchronous serial line. The line is oversampled at sixteen times the bit rate, with the rate set by a one-cycle enable input. Each frame opens with a low start bit and carries eight data bits, least significant first. A parity bit follows when parity is enabled, and a high stop bit closes the frame. The byte is placed in a receive buffer. A three-bit status register records a parity mismatch, a missing stop bit, or a byte that arrived while the previous one was still unread.

Software sees two readable locations through a single-strobe read port. Reading the buffer acknowledges the byte and wipes the status. For this reason the status must be read first. Two interrupt pulses mark the end of each frame. The error pulse comes first, and the completion pulse follows one cycle later. A mode input can withhold the completion pulse for frames that carry an error. A build parameter can remove the error pulse entirely, while the status flags keep working.

Top module: `uart_rx_errstat`

## Requirements
- R1: A frame is received as a low start bit, eight data bits sampled LSB first at the middle of each 16-tick window, an optional parity bit and a stop bit. The byte is then readable at read address 0 and `buf_full_o` rises.
- R2: `parity_mode_i` selects 00 none (no parity bit on the line, and no parity error is possible), 01 even, 10 odd, or 11 parity bit always 0. A mismatch sets status bit 2 (value 0x04).
- R3: A stop bit sampled low sets status bit 1 (value 0x02).
- R4: A frame that completes while `buf_full_o` is still set sets status bit 0 (value 0x01). The buffer takes the new byte and `buf_full_o` stays set.
- R5: A read at address 0 clears the status to 0 and drops `buf_full_o`. A read at address 1 returns the status in bits 2:0 and changes nothing.
- R6: Each completed frame replaces the whole status with the errors of that frame. Flags from an earlier frame do not survive.
- R7: A frame with no error gives a one-cycle `done_irq_o` pulse. A frame with any error gives a one-cycle `err_irq_o` pulse, and `done_irq_o` follows in the next cycle. The two are never high together.
- R8: When `err_mask_i` is 1 and the frame has an error, no `done_irq_o` pulse is produced for that frame.
- R9: With parameter `ERR_IRQ_EN` = 0, `err_irq_o` never rises. Status flags and the completion pulse behave as in R2 to R8.
- R10: A start bit that reads high at its midpoint is discarded. No frame is produced and the buffer is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| parity_mode_i | input | 2 | 00 none, 01 even, 10 odd, 11 zero parity |
| err_mask_i | input | 1 | 1: suppress completion pulse on errored frames |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| rd_addr_i | input | 1 | 0 receive buffer, 1 status |
| rd_data_o | output | 8 | Read data, combinational from address |
| buf_full_o | output | 1 | Unread byte present |
| err_irq_o | output | 1 | Receive-error pulse |
| done_irq_o | output | 1 | Receive-complete pulse |

## Verification
The properties assume that `parity_mode_i` and `err_mask_i` do not change while a frame is on the line. They also assume that two frames never complete within three cycles of each other, which holds because a frame takes at least 150 ticks. The bench changes mode and mask only between frames, with the line idle. It drives every bit for exactly 16 ticks. A bad stop bit is held low only past its midpoint, so the line is high again before the next start. Random frames mix the parity modes, injected errors, skipped reads and the mask, all drawn from a fixed seed.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00, PAR_EVEN = 2'b01, PAR_ODD = 2'b10, PAR_ZERO = 2'b11
  } par_mode_e;

  localparam int STAT_W  = 3;
  localparam int STAT_PE = 2;
  localparam int STAT_FE = 1;
  localparam int STAT_OV = 0;

  localparam logic ADDR_BUF  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        parity_mode_i,
  output logic              frame_v_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pe_o,
  output logic              fe_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = OVS / 2;

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              par_bad;
  logic              win_end;

  assign win_end = (cnt_q == CNT_W'(OVS - 1));

  always_comb begin
    unique case (par_mode_e'(parity_mode_i))
      PAR_EVEN: par_bad = (par_q != ^sh_q);
      PAR_ODD:  par_bad = (par_q != ~^sh_q);
      PAR_ZERO: par_bad = par_q;
      default:  par_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
      frame_v_o <= 1'b0;
      pe_o      <= 1'b0;
      fe_o      <= 1'b0;
    end else begin
      frame_v_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: if (!rxd_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
          ST_START: begin
            if (cnt_q == CNT_W'(HALF - 1)) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rxd_i ? ST_IDLE : ST_DATA;  // glitch rejection
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (win_end) begin
              cnt_q <= '0;
              sh_q  <= {rxd_i, sh_q[DATA_W-1:1]};
              idx_q <= idx_q + 1'b1;
              if (idx_q == IDX_W'(DATA_W - 1))
                st_q <= (parity_mode_i == PAR_NONE) ? ST_STOP : ST_PAR;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (win_end) begin
              cnt_q <= '0;
              par_q <= rxd_i;
              st_q  <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (win_end) begin
              cnt_q     <= '0;
              frame_v_o <= 1'b1;
              fe_o      <= !rxd_i;
              pe_o      <= par_bad;
              st_q      <= ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q;
endmodule

// File: rtl/uart_rx_regfile.sv
module uart_rx_regfile
  import uart_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit ERR_IRQ_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_v_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              err_mask_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              buf_full_o,
  output logic              err_irq_o,
  output logic              done_irq_o
);
  logic [DATA_W-1:0] buf_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_nxt;
  logic              full_q;
  logic              pend_q;
  logic              rd_buf;
  logic              any_err;

  assign rd_buf            = rd_en_i && (rd_addr_i == ADDR_BUF);
  assign stat_nxt[STAT_PE] = pe_i;
  assign stat_nxt[STAT_FE] = fe_i;
  assign stat_nxt[STAT_OV] = full_q && !rd_buf;
  assign any_err           = |stat_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      stat_q     <= '0;
      full_q     <= 1'b0;
      pend_q     <= 1'b0;
      err_irq_o  <= 1'b0;
      done_irq_o <= 1'b0;
    end else begin
      err_irq_o  <= 1'b0;
      done_irq_o <= pend_q;
      pend_q     <= 1'b0;
      if (frame_v_i) begin
        buf_q      <= data_i;
        stat_q     <= stat_nxt;
        full_q     <= 1'b1;
        err_irq_o  <= any_err && ERR_IRQ_EN;
        done_irq_o <= !any_err;
        pend_q     <= any_err && !err_mask_i;  // completion trails error by one cycle
      end else if (rd_buf) begin
        stat_q <= '0;
        full_q <= 1'b0;
      end
    end
  end

  assign rd_data_o  = (rd_addr_i == ADDR_STAT) ? {{(DATA_W-STAT_W){1'b0}}, stat_q} : buf_q;
  assign stat_o     = stat_q;
  assign buf_full_o = full_q;
endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit ERR_IRQ_EN  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        parity_mode_i,
  input  logic              err_mask_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              buf_full_o,
  output logic              err_irq_o,
  output logic              done_irq_o
);
  logic              rxd_s;
  logic              frame_v;
  logic [DATA_W-1:0] frame_data;
  logic              frame_pe;
  logic              frame_fe;
  logic [STAT_W-1:0] stat_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_rx_deser #(.DATA_W(DATA_W), .OVS(OVS)) i_deser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .rxd_i        (rxd_s),
    .parity_mode_i(parity_mode_i),
    .frame_v_o    (frame_v),
    .data_o       (frame_data),
    .pe_o         (frame_pe),
    .fe_o         (frame_fe)
  );

  uart_rx_regfile #(.DATA_W(DATA_W), .ERR_IRQ_EN(ERR_IRQ_EN)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_v_i (frame_v),
    .data_i    (frame_data),
    .pe_i      (frame_pe),
    .fe_i      (frame_fe),
    .err_mask_i(err_mask_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .stat_o    (stat_q),
    .buf_full_o(buf_full_o),
    .err_irq_o (err_irq_o),
    .done_irq_o(done_irq_o)
  );
endmodule

// File: rtl/uart_rx_errstat_chk.sv
module uart_rx_errstat_chk #(
  parameter bit ERR_IRQ_EN = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_v,
  input logic       frame_pe,
  input logic       frame_fe,
  input logic       err_mask_i,
  input logic       rd_en_i,
  input logic       rd_addr_i,
  input logic [2:0] stat_q,
  input logic       buf_full_o,
  input logic       err_irq_o,
  input logic       done_irq_o
);
  p_full_after_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_v |=> buf_full_o);

  p_ovr_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_v && buf_full_o && !(rd_en_i && !rd_addr_i) |=> stat_q[0] && buf_full_o);

  p_rd_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !rd_addr_i && !frame_v |=> stat_q == 3'b000 && !buf_full_o);

  p_stat_rd_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i && !frame_v |=> $stable(stat_q) && $stable(buf_full_o));

  p_err_has_stat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> stat_q != 3'b000);

  p_irq_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_irq_o, done_irq_o}));

  p_err_then_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_v && (frame_pe || frame_fe) && !err_mask_i |-> ##2 done_irq_o);

  p_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_v && (frame_pe || frame_fe) && err_mask_i |-> ##1 !done_irq_o ##1 !done_irq_o);

  p_no_err_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> ERR_IRQ_EN);
endmodule

bind uart_rx_errstat uart_rx_errstat_chk #(.ERR_IRQ_EN(ERR_IRQ_EN)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_v   (frame_v),
  .frame_pe  (frame_pe),
  .frame_fe  (frame_fe),
  .err_mask_i(err_mask_i),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .stat_q    (stat_q),
  .buf_full_o(buf_full_o),
  .err_irq_o (err_irq_o),
  .done_irq_o(done_irq_o)
);

// File: tb/test_uart_rx_errstat.sv
module test_uart_rx_errstat;
  localparam int BITC = 32;  // clocks per bit: tick every 2 clocks, 16 ticks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rxd = 1'b1;
  logic [1:0] pmode = 2'b00;
  logic       mask = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rdata_a, rdata_b;
  logic       full_a, full_b, err_a, err_b, done_a, done_b;

  int n_tests = 0, n_fail = 0;
  int n_err_a = 0, n_done_a = 0, n_ord_a = 0, n_err_b = 0, n_done_b = 0;
  logic prev_err_a = 1'b0;
  bit   exp_full = 1'b0;
  logic [2:0] exp_stat = 3'b000;
  logic [7:0] exp_buf = 8'h00;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  uart_rx_errstat i_uart_rx_errstat (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .parity_mode_i(pmode), .err_mask_i(mask), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rdata_a), .buf_full_o(full_a), .err_irq_o(err_a), .done_irq_o(done_a)
  );

  uart_rx_errstat #(.ERR_IRQ_EN(1'b0)) i_uart_rx_errstat_noirq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .parity_mode_i(pmode), .err_mask_i(mask), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rdata_b), .buf_full_o(full_b), .err_irq_o(err_b), .done_irq_o(done_b)
  );

  always @(posedge clk) begin
    if (err_a) n_err_a++;
    if (done_a) n_done_a++;
    if (done_a && prev_err_a) n_ord_a++;
    if (err_b) n_err_b++;
    if (done_b) n_done_b++;
    prev_err_a <= err_a;
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic par_bit(logic [7:0] d, logic [1:0] m);
    case (m)
      2'b01:   return ^d;
      2'b10:   return ~^d;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(logic b, int n);
    @(negedge clk) rxd = b;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic rd(logic a, output logic [7:0] da, output logic [7:0] db);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 da = rdata_a; db = rdata_b;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_all(string req);
    logic [7:0] a, b;
    rd(1'b1, a, b);
    chk(req, a, exp_stat);
    chk({req, " no-irq build"}, b, exp_stat);
    rd(1'b0, a, b);
    chk("R1 buffer", a, exp_buf);
    chk("R1 buffer no-irq build", b, exp_buf);
    exp_stat = 3'b000; exp_full = 1'b0;
    chk("R5 full cleared", full_a, 0);
    rd(1'b1, a, b);
    chk("R5 status cleared", a, 0);
  endtask

  task automatic frame(logic [7:0] d, logic [1:0] m, bit bad_par, bit bad_stop,
                       bit msk, bit do_read, string req);
    int e0, d0, o0, eb0, db0;
    bit pe, any;
    @(negedge clk);
    pmode = m; mask = msk;
    e0 = n_err_a; d0 = n_done_a; o0 = n_ord_a; eb0 = n_err_b; db0 = n_done_b;
    drive(1'b0, BITC);
    for (int i = 0; i < 8; i++) drive(d[i], BITC);
    if (m != 2'b00) drive(par_bit(d, m) ^ bad_par, BITC);
    if (bad_stop) begin
      drive(1'b0, 24);
      drive(1'b1, 8);
    end else drive(1'b1, BITC);
    drive(1'b1, BITC);
    pe = bad_par && (m != 2'b00);
    exp_stat = {pe, bad_stop, exp_full};
    exp_full = 1'b1;
    exp_buf = d;
    any = |exp_stat;
    chk("R7 error pulse count", n_err_a - e0, any);
    chk("R8 done pulse count", n_done_a - d0, (any && msk) ? 0 : 1);
    chk("R7 error then done order", n_ord_a - o0, (any && !msk) ? 1 : 0);
    chk("R9 no error pulse", n_err_b - eb0, 0);
    chk("R9 done pulse count", n_done_b - db0, (any && msk) ? 0 : 1);
    chk("R4 buffer full", full_a, 1);
    if (do_read) read_all(req);
  endtask

  initial begin
    logic [7:0] a, b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset full", full_a, 0);
    chk("R7 reset irqs", {err_a, done_a}, 0);
    rd(1'b1, a, b);
    chk("R5 reset status", a, 0);

    frame(8'hA5, 2'b01, 0, 0, 0, 1, "R1 clean even");
    frame(8'h3C, 2'b00, 0, 0, 0, 1, "R2 none parity");
    frame(8'h3C, 2'b00, 1, 0, 0, 1, "R2 none ignores parity");
    frame(8'h5A, 2'b10, 1, 0, 0, 1, "R2 odd parity error");
    frame(8'h81, 2'b01, 1, 0, 0, 1, "R2 even parity error");
    frame(8'hFF, 2'b11, 0, 0, 0, 1, "R2 zero parity ok");
    frame(8'h00, 2'b11, 1, 0, 0, 1, "R2 zero parity error");
    frame(8'hC3, 2'b01, 0, 1, 0, 1, "R3 framing error");
    frame(8'h11, 2'b00, 0, 0, 0, 0, "R4 first");
    frame(8'h22, 2'b00, 0, 0, 0, 1, "R4 overrun");
    frame(8'h44, 2'b01, 0, 1, 0, 0, "R6 first");
    rd(1'b1, a, b);
    chk("R6 framing held", a, 3'b010);
    chk("R5 status read keeps full", full_a, 1);
    rd(1'b1, a, b);
    chk("R5 status read keeps status", a, 3'b010);
    frame(8'h55, 2'b01, 0, 0, 0, 1, "R6 replaced by overrun only");
    frame(8'h96, 2'b10, 1, 0, 1, 1, "R8 masked error");
    frame(8'h69, 2'b01, 0, 1, 1, 1, "R8 masked framing");

    drive(1'b0, 8);
    drive(1'b1, 12 * BITC);
    chk("R10 glitch no frame", full_a, 0);
    chk("R10 glitch no done", n_done_a, n_done_b);
    frame(8'h7E, 2'b00, 0, 0, 0, 1, "R10 receive after glitch");

    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      logic [1:0] m;
      bit bp, bs, mk, rdd;
      d = 8'($urandom);
      m = 2'($urandom);
      bp = ($urandom % 5) == 0;
      bs = ($urandom % 7) == 0;
      mk = ($urandom % 3) == 0;
      rdd = ($urandom % 3) != 0;
      frame(d, m, bp, bs, mk, rdd, "R6 random status");
    end
    if (exp_full) read_all("R6 final status");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule